// File: doc/BRIEF.md
# Operand Queue Register with Live Head

This block is a circular register file for intermediate operands. Results are written at a tail pointer, and operands are taken from a head pointer. A third pointer, the live head, trails the head and marks the start of a window of consumed entries that may still be read again. Entries inside that window cannot be overwritten. The window exists only while the live head is frozen. In automatic mode the live head moves with the head, so the window is empty.

Each cycle, one result may be produced and zero, one or two operands may be consumed. A stop request freezes the live head and an auto request releases it. Two combinational read ports return any slot by its absolute index, which the surrounding addressing logic computes. Every slot is reported as one of four classes: empty, valid, live or dead. The reset input is asynchronous and active low, and its release is synchronised inside the block.

Top module: `live_operand_queue`

## Requirements
- R1: After reset, the head, tail and live head pointers are all 0, the queue is in automatic mode, `q_empty` is 1, `q_full` is 0, and every slot class is EMPTY (code 0).
- R2: An accepted produce writes `prod_data` to the slot at the tail. After the clock edge the tail is one higher, modulo 16, and the written value can be read at that slot.
- R3: A consume count of 0, 1 or 2 advances the head by that count when the count is no larger than the number of valid entries (tail minus head, modulo 16). A larger count is refused and the head does not move.
- R4: In automatic mode, the live head equals the head after every clock edge.
- R5: A stop request freezes the live head. It keeps its value on every edge until an auto request without a stop request. When both requests arrive together, stop wins.
- R6: An auto request without a stop request releases the live head, and after that edge it equals the new head.
- R7: `q_full` is 1 when the tail plus one, modulo 16, equals the live head. A produce made while full is refused: the tail does not move and no slot is written.
- R8: A refused produce leaves the live slots and the slot at the tail unchanged, as seen through the read ports.
- R9: Each 2-bit field `slot_class[2*i+1:2*i]` gives the class of slot i. A slot from the head up to, but not including, the tail is VALID (1). A slot from the live head up to, but not including, the head is LIVE (2). Any other slot that has been written since reset is DEAD (3). The rest are EMPTY (0).
- R10: The two read ports are independent and each returns the stored word of any slot, in the same cycle.
- R11: `q_empty` is 1 exactly when the head equals the tail.
- R12: A produce and a consume in the same cycle both take effect, each judged on the pointer values before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prod_req | input | 1 | Produce one result this cycle |
| prod_data | input | 32 | Result to store at the tail |
| cons_cnt | input | 2 | Number of operands consumed this cycle (0 to 2) |
| live_stop | input | 1 | Freeze the live head |
| live_auto | input | 1 | Release the live head |
| rd_a_idx | input | 4 | Absolute slot index for read port A |
| rd_b_idx | input | 4 | Absolute slot index for read port B |
| rd_a_data | output | 32 | Word stored at slot `rd_a_idx` |
| rd_b_data | output | 32 | Word stored at slot `rd_b_idx` |
| head_ptr | output | 4 | Current head |
| tail_ptr | output | 4 | Current tail |
| live_ptr | output | 4 | Current live head |
| live_frozen | output | 1 | 1 while the live head is frozen |
| q_full | output | 1 | Produce would land on the live head |
| q_empty | output | 1 | No valid entries remain |
| slot_class | output | 32 | Class of each slot, two bits per slot |

## Verification
The assertions assume that `cons_cnt` never exceeds 2. They also assume that requests are presented only after the internal reset release, because the pointer checks are disabled while that synchronised reset is low. The stimulus drives only counts 0 to 2 and waits several cycles after reset before the first request. It deliberately asks for consumes from an empty queue and produces into a full one. These cases exercise the refusal paths, and the inputs still stay inside the assumed range.

// File: rtl/qlr_pkg.sv
package qlr_pkg;
  typedef enum logic [1:0] {
    SLOT_EMPTY = 2'd0,
    SLOT_VALID = 2'd1,
    SLOT_LIVE  = 2'd2,
    SLOT_DEAD  = 2'd3
  } slot_class_e;
endpackage

// File: rtl/qlr_rst_sync.sv
module qlr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/qlr_ptr_ctrl.sv
// Pointer control. DEPTH must be a power of two so that pointers wrap naturally.
module qlr_ptr_ctrl #(
  parameter  int DEPTH = 16,
  parameter  int CNT_W = 2,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prod_req,
  input  logic [CNT_W-1:0] cons_cnt,
  input  logic             stop_req,
  input  logic             auto_req,
  output logic [PTR_W-1:0] head,
  output logic [PTR_W-1:0] tail,
  output logic [PTR_W-1:0] live,
  output logic             frozen,
  output logic             full,
  output logic             empty,
  output logic             wr_en
);
  logic [PTR_W-1:0] head_q, head_d, tail_q, tail_d, live_q, live_d;
  logic [PTR_W-1:0] fill, cons_w;
  logic             frozen_q, frozen_d;
  logic             cons_ok, head_en, tail_en, live_en, frozen_en;

  // next-state logic
  always_comb begin
    fill      = tail_q - head_q;
    cons_w    = PTR_W'(cons_cnt);
    full      = (tail_q + PTR_W'(1)) == live_q;
    empty     = (tail_q == head_q);
    cons_ok   = (cons_w <= fill);
    head_en   = cons_ok && (cons_cnt != '0);
    head_d    = head_q + cons_w;
    tail_en   = prod_req && !full;
    tail_d    = tail_q + PTR_W'(1);
    frozen_d  = stop_req | (frozen_q & ~auto_req);
    frozen_en = (frozen_d != frozen_q);
    live_en   = !frozen_d;
    live_d    = head_en ? head_d : head_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q   <= '0;
      tail_q   <= '0;
      live_q   <= '0;
      frozen_q <= 1'b0;
    end else begin
      if (head_en)   head_q   <= head_d;
      if (tail_en)   tail_q   <= tail_d;
      if (live_en)   live_q   <= live_d;
      if (frozen_en) frozen_q <= frozen_d;
    end
  end

  assign head   = head_q;
  assign tail   = tail_q;
  assign live   = live_q;
  assign frozen = frozen_q;
  assign wr_en  = tail_en;

  assert_empty_consume_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && cons_cnt != '0) |=> $stable(head_q));

  assert_auto_track_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !frozen_q |-> (live_q == head_q));

  assert_frozen_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req || (frozen_q && !auto_req)) |=> $stable(live_q));

  assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_req && !stop_req) |=> (live_q == head_q));

  assert_full_refuse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (prod_req && full) |=> $stable(tail_q));
endmodule

// File: rtl/qlr_store.sv
module qlr_store #(
  parameter  int DEPTH  = 16,
  parameter  int DATA_W = 32,
  localparam int PTR_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [PTR_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [PTR_W-1:0]  ra_idx,
  input  logic [PTR_W-1:0]  rb_idx,
  output logic [DATA_W-1:0] ra_data,
  output logic [DATA_W-1:0] rb_data,
  output logic [DEPTH-1:0]  written
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DEPTH-1:0]  written_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      written_q <= '0;
    end else if (we) begin
      mem_q[waddr]     <= wdata;
      written_q[waddr] <= 1'b1;
    end
  end

  assign ra_data = mem_q[ra_idx];
  assign rb_data = mem_q[rb_idx];
  assign written = written_q;

  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (mem_q[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/qlr_classify.sv
module qlr_classify
  import qlr_pkg::*;
#(
  parameter  int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic [PTR_W-1:0]   head,
  input  logic [PTR_W-1:0]   tail,
  input  logic [PTR_W-1:0]   live,
  input  logic [DEPTH-1:0]   written,
  output logic [2*DEPTH-1:0] classes
);
  logic [PTR_W-1:0] span_valid, span_live;

  always_comb begin
    span_valid = tail - head;
    span_live  = head - live;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [PTR_W-1:0] off_h, off_l;
    slot_class_e      cls;
    always_comb begin
      off_h = PTR_W'(g) - head;
      off_l = PTR_W'(g) - live;
      if (off_h < span_valid)      cls = SLOT_VALID;
      else if (off_l < span_live)  cls = SLOT_LIVE;
      else if (written[g])         cls = SLOT_DEAD;
      else                         cls = SLOT_EMPTY;
    end
    assign classes[2*g +: 2] = cls;
  end
endmodule

// File: rtl/live_operand_queue.sv
module live_operand_queue #(
  parameter  int DEPTH    = 16,
  parameter  int DATA_W   = 32,
  parameter  int CONS_MAX = 2,
  localparam int PTR_W    = $clog2(DEPTH),
  localparam int CNT_W    = $clog2(CONS_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prod_req,
  input  logic [DATA_W-1:0] prod_data,
  input  logic [CNT_W-1:0]  cons_cnt,
  input  logic              live_stop,
  input  logic              live_auto,
  input  logic [PTR_W-1:0]  rd_a_idx,
  input  logic [PTR_W-1:0]  rd_b_idx,
  output logic [DATA_W-1:0] rd_a_data,
  output logic [DATA_W-1:0] rd_b_data,
  output logic [PTR_W-1:0]  head_ptr,
  output logic [PTR_W-1:0]  tail_ptr,
  output logic [PTR_W-1:0]  live_ptr,
  output logic              live_frozen,
  output logic              q_full,
  output logic              q_empty,
  output logic [2*DEPTH-1:0] slot_class
);
  logic             rst_n_int, wr_en;
  logic [DEPTH-1:0] written;

  qlr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  qlr_ptr_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .prod_req (prod_req),
    .cons_cnt (cons_cnt),
    .stop_req (live_stop),
    .auto_req (live_auto),
    .head     (head_ptr),
    .tail     (tail_ptr),
    .live     (live_ptr),
    .frozen   (live_frozen),
    .full     (q_full),
    .empty    (q_empty),
    .wr_en    (wr_en)
  );

  qlr_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .we      (wr_en),
    .waddr   (tail_ptr),
    .wdata   (prod_data),
    .ra_idx  (rd_a_idx),
    .rb_idx  (rd_b_idx),
    .ra_data (rd_a_data),
    .rb_data (rd_b_data),
    .written (written)
  );

  qlr_classify #(.DEPTH(DEPTH)) u_cls (
    .head    (head_ptr),
    .tail    (tail_ptr),
    .live    (live_ptr),
    .written (written),
    .classes (slot_class)
  );

  assert_cons_range_R3: assert property (@(posedge clk) disable iff (!rst_n_int)
    cons_cnt <= CNT_W'(CONS_MAX));
endmodule

// File: tb/live_operand_queue_bench.sv
module live_operand_queue_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        prod_req = 1'b0;
  logic [31:0] prod_data = '0;
  logic [1:0]  cons_cnt = '0;
  logic        live_stop = 1'b0, live_auto = 1'b0;
  logic [3:0]  rd_a_idx = '0, rd_b_idx = '0;
  logic [31:0] rd_a_data, rd_b_data;
  logic [3:0]  head_ptr, tail_ptr, live_ptr;
  logic        live_frozen, q_full, q_empty;
  logic [31:0] slot_class;

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  live_operand_queue u_live_operand_queue (
    .clk(clk), .rst_n(rst_n), .prod_req(prod_req), .prod_data(prod_data),
    .cons_cnt(cons_cnt), .live_stop(live_stop), .live_auto(live_auto),
    .rd_a_idx(rd_a_idx), .rd_b_idx(rd_b_idx), .rd_a_data(rd_a_data),
    .rd_b_data(rd_b_data), .head_ptr(head_ptr), .tail_ptr(tail_ptr),
    .live_ptr(live_ptr), .live_frozen(live_frozen), .q_full(q_full),
    .q_empty(q_empty), .slot_class(slot_class)
  );

  // row: stop rel cons[2] prod wdata[32] | head[4] tail[4] live[4] full empty
  localparam logic [50:0] VECS [0:10] = '{
    {1'b0,1'b0,2'd0,1'b1,32'hA000_0000, 4'd0,4'd1,4'd0,1'b0,1'b0}, // R2
    {1'b0,1'b0,2'd0,1'b1,32'hA000_0011, 4'd0,4'd2,4'd0,1'b0,1'b0}, // R2
    {1'b0,1'b0,2'd1,1'b1,32'hA000_0022, 4'd1,4'd3,4'd1,1'b0,1'b0}, // R12 R4
    {1'b1,1'b0,2'd2,1'b0,32'h0,         4'd3,4'd3,4'd1,1'b0,1'b1}, // R5 R11
    {1'b0,1'b0,2'd1,1'b1,32'hA000_0033, 4'd3,4'd4,4'd1,1'b0,1'b0}, // R3 refused
    {1'b0,1'b0,2'd1,1'b0,32'h0,         4'd4,4'd4,4'd1,1'b0,1'b1}, // R5
    {1'b0,1'b1,2'd0,1'b0,32'h0,         4'd4,4'd4,4'd4,1'b0,1'b1}, // R6
    {1'b1,1'b1,2'd0,1'b1,32'hA000_0044, 4'd4,4'd5,4'd4,1'b0,1'b0}, // R5 stop wins
    {1'b0,1'b0,2'd1,1'b0,32'h0,         4'd5,4'd5,4'd4,1'b0,1'b1}, // R5
    {1'b0,1'b1,2'd0,1'b1,32'hA000_0055, 4'd5,4'd6,4'd5,1'b0,1'b0}, // R6
    {1'b0,1'b0,2'd2,1'b0,32'h0,         4'd5,4'd6,4'd5,1'b0,1'b0}  // R3 refused
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic st, input logic rl, input logic [1:0] c,
                       input logic p, input logic [31:0] d);
    live_stop = st; live_auto = rl; cons_cnt = c; prod_req = p; prod_data = d;
    @(negedge clk);
    live_stop = 1'b0; live_auto = 1'b0; cons_cnt = '0; prod_req = 1'b0;
  endtask

  task automatic read_check(input string tag, input logic [3:0] idx, input logic [31:0] exp);
    rd_a_idx = idx; rd_b_idx = 4'd15 - idx;
    #1;
    check(tag, {32'h0, rd_a_data}, {32'h0, exp});
  endtask

  function automatic logic [31:0] class_vec(input int h, input int t, input int l,
                                            input logic [15:0] wr);
    logic [31:0] v;
    for (int i = 0; i < 16; i++) begin
      int oh, ol;
      oh = (i - h + 16) % 16;
      ol = (i - l + 16) % 16;
      if (oh < (t - h + 16) % 16)      v[2*i +: 2] = 2'd1;
      else if (ol < (h - l + 16) % 16) v[2*i +: 2] = 2'd2;
      else if (wr[i])                  v[2*i +: 2] = 2'd3;
      else                             v[2*i +: 2] = 2'd0;
    end
    return v;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 head", 64'(head_ptr), 64'd0);
    check("R1 tail", 64'(tail_ptr), 64'd0);
    check("R1 live", 64'(live_ptr), 64'd0);
    check("R1 flags", {61'd0, live_frozen, q_full, q_empty}, 64'b001);
    check("R1 classes", 64'(slot_class), 64'd0);

    // table walk: R2 R3 R4 R5 R6 R11 R12
    for (int r = 0; r < 11; r++) begin
      logic [50:0] v;
      v = VECS[r];
      drive(v[50], v[49], v[48:47], v[46], v[45:14]);
      check($sformatf("R3 R4 R5 R6 R11 R12 row%0d head", r), 64'(head_ptr), 64'(v[13:10]));
      check($sformatf("R2 R12 row%0d tail", r), 64'(tail_ptr), 64'(v[9:6]));
      check($sformatf("R4 R5 R6 row%0d live", r), 64'(live_ptr), 64'(v[5:2]));
      check($sformatf("R7 R11 row%0d flags", r), {62'd0, q_full, q_empty}, 64'(v[1:0]));
    end

    // R2 R10 stored data through both ports
    for (int i = 0; i < 6; i++) begin
      logic [31:0] e;
      e = 32'hA000_0000 + 32'(i) * 32'h11;
      read_check("R2 R10 port A", 4'(i), e);
      rd_a_idx = 4'd0; rd_b_idx = 4'(i);
      #1;
      check("R10 port B", {32'h0, rd_b_data}, {32'h0, e});
    end

    // R9 classes: slots 0..4 dead, 5 valid, rest empty
    check("R9 classes auto", 64'(slot_class), 64'(class_vec(5, 6, 5, 16'h003F)));
    drive(1'b1, 1'b0, 2'd1, 1'b0, 32'h0);
    check("R9 classes live", 64'(slot_class), 64'(class_vec(6, 6, 5, 16'h003F)));
    check("R5 frozen flag", 64'(live_frozen), 64'd1);

    // R7 fill to full with live head frozen at 5
    for (int k = 0; k < 14; k++) drive(1'b0, 1'b0, 2'd0, 1'b1, 32'hB000_0000 + 32'(k));
    check("R7 tail at full", 64'(tail_ptr), 64'd4);
    check("R7 full flag", 64'(q_full), 64'd1);
    check("R9 classes full", 64'(slot_class), 64'(class_vec(6, 4, 5, 16'hFFFF)));
    drive(1'b0, 1'b0, 2'd0, 1'b1, 32'hDEAD_BEEF);
    check("R7 tail stays", 64'(tail_ptr), 64'd4);
    read_check("R8 tail slot intact", 4'd4, 32'hA000_0044);
    read_check("R8 live slot intact", 4'd5, 32'hA000_0055);
    read_check("R2 wrapped write", 4'd3, 32'hB000_000D);

    // R6 release frees the live slot, next produce lands at slot 4
    drive(1'b0, 1'b1, 2'd0, 1'b0, 32'h0);
    check("R6 live follows", 64'(live_ptr), 64'd6);
    check("R7 full cleared", 64'(q_full), 64'd0);
    drive(1'b0, 1'b0, 2'd0, 1'b1, 32'hC000_0001);
    read_check("R2 after release", 4'd4, 32'hC000_0001);
    check("R7 full again", 64'(q_full), 64'd1);

    // R3 consume two, then R12 consume and produce together while full
    drive(1'b0, 1'b0, 2'd2, 1'b1, 32'hC000_0002);
    check("R12 head", 64'(head_ptr), 64'd8);
    check("R12 tail refused", 64'(tail_ptr), 64'd5);
    check("R4 live", 64'(live_ptr), 64'd8);

    finish_run();
  end
endmodule